// File: doc/BRIEF.md
# Warp Scoreboard Instruction Buffer

This block sits between instruction fetch and operand collection for one warp. Each fetched instruction carries an opaque opcode tag, one destination register id and up to two source register ids, each source with an enable bit. Accepted instructions are parked in a small ordered buffer. A scoreboard records the destination registers of instructions that have issued but have not yet written back.

Every cycle the block compares each parked instruction with the pending-write entries. An instruction is eligible when none of its live register ids matches a pending entry. The oldest eligible instruction is offered on the issue port, as long as a scoreboard slot can take its destination. A writeback-clear input removes a register from the scoreboard, and that can release parked instructions.

Fetch has valid/ready backpressure, and issue has a valid/ready handshake. Register ids are 5 bits wide. The buffer depth and the number of scoreboard slots are parameters (default 4 and 4).

Top module: `warp_issue_buf`

## Requirements
- R1: An instruction accepted on a fetch handshake can first be offered on the issue port in the cycle after acceptance. The issue outputs carry its opcode, destination and sources unchanged.
- R2: A parked instruction is not issued while its destination matches a pending scoreboard entry, or while an enabled source matches one. A source whose enable bit is 0 takes no part in the comparison.
- R3: A writeback-clear of register r removes r from the scoreboard at the next clock edge. Instructions blocked only by r may then issue.
- R4: fetch_ready_o is 0 exactly when the buffer holds DEPTH instructions. While it is 0, no instruction is accepted.
- R5: An issue handshake records the issued destination in a free scoreboard slot. Nothing is offered for issue while every slot is occupied and no slot is being cleared in the same cycle.
- R6: Among eligible parked instructions the oldest is offered first. A younger independent instruction may pass an older blocked one.
- R7: A slot freed by a writeback-clear can take an issuing destination in that same cycle.
- R8: After reset the buffer and the scoreboard are empty: fetch_ready_o is 1 and issue_valid_o is 0.
- R9: While issue_ready_i is 0, an offered instruction stays in the buffer and is issued later, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch offers an instruction |
| fetch_ready_o | output | 1 | Buffer can accept an instruction |
| fetch_op_i | input | 8 | Opcode tag of the fetched instruction |
| fetch_dst_i | input | 5 | Destination register id |
| fetch_src0_i | input | 5 | First source register id |
| fetch_src0_en_i | input | 1 | First source is used |
| fetch_src1_i | input | 5 | Second source register id |
| fetch_src1_en_i | input | 1 | Second source is used |
| issue_valid_o | output | 1 | An instruction is offered for issue |
| issue_ready_i | input | 1 | Downstream takes the offered instruction |
| issue_op_o | output | 8 | Opcode tag of the offered instruction |
| issue_dst_o | output | 5 | Destination register id |
| issue_src0_o | output | 5 | First source register id |
| issue_src0_en_o | output | 1 | First source is used |
| issue_src1_o | output | 5 | Second source register id |
| issue_src1_en_o | output | 1 | Second source is used |
| wb_valid_i | input | 1 | A completed instruction releases a register |
| wb_reg_i | input | 5 | Register id to clear from the scoreboard |

## Verification
The hardest state to reach is a full scoreboard with an independent instruction waiting, because only then do the slot-full block and the same-cycle slot reuse show. The stimulus holds issue_ready_i low while it fills the buffer with four independent instructions, and a fifth fetch then meets backpressure. Releasing issue_ready_i drains the four into all four slots. The bench then checks that the waiting fifth stays blocked, and that it issues in the very cycle a one-cycle writeback clears a slot. Overtaking is reached by placing an independent instruction behind one that is blocked on a source.

// File: rtl/wib_pkg.sv
package wib_pkg;
  localparam int unsigned WIB_REG_W = 5;
  localparam int unsigned WIB_OP_W  = 8;

  typedef struct packed {
    logic [WIB_OP_W-1:0]  op;
    logic [WIB_REG_W-1:0] dst;
    logic [WIB_REG_W-1:0] src0;
    logic                 src0_en;
    logic [WIB_REG_W-1:0] src1;
    logic                 src1_en;
  } wib_instr_t;
endpackage

// File: rtl/wib_scoreboard.sv
module wib_scoreboard
  import wib_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              clr_valid_i,
  input  logic [WIB_REG_W-1:0]              clr_reg_i,
  input  logic                              set_valid_i,
  input  logic [WIB_REG_W-1:0]              set_reg_i,
  output logic [SLOTS-1:0]                  pend_valid_o,
  output logic [SLOTS-1:0][WIB_REG_W-1:0]   pend_reg_o,
  output logic                              has_free_o
);
  logic [SLOTS-1:0] valid_q, keep;
  logic [SLOTS-1:0][WIB_REG_W-1:0] reg_q;
  logic [SLOTS-1:0] free_oh;

  // clear is applied before the free-slot search
  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      keep[i] = valid_q[i] && !(clr_valid_i && reg_q[i] == clr_reg_i);
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!keep[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign has_free_o = |free_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      reg_q   <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (set_valid_i && free_oh[i]) begin
          valid_q[i] <= 1'b1;
          reg_q[i]   <= set_reg_i;
        end else begin
          valid_q[i] <= keep[i];
        end
      end
    end
  end

  assign pend_valid_o = valid_q;
  assign pend_reg_o   = reg_q;
endmodule

// File: rtl/wib_hazard.sv
module wib_hazard
  import wib_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  wib_instr_t                        instr_i,
  input  logic [SLOTS-1:0]                  pend_valid_i,
  input  logic [SLOTS-1:0][WIB_REG_W-1:0]   pend_reg_i,
  output logic                              hit_o
);
  logic [SLOTS-1:0] slot_hit;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign slot_hit[s] = pend_valid_i[s] &&
                         ((instr_i.dst == pend_reg_i[s]) ||
                          (instr_i.src0_en && instr_i.src0 == pend_reg_i[s]) ||
                          (instr_i.src1_en && instr_i.src1 == pend_reg_i[s]));
  end

  assign hit_o = |slot_hit;
endmodule

// File: rtl/warp_issue_buf.sv
module warp_issue_buf
  import wib_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned SB_SLOTS = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fetch_valid_i,
  output logic                 fetch_ready_o,
  input  logic [WIB_OP_W-1:0]  fetch_op_i,
  input  logic [WIB_REG_W-1:0] fetch_dst_i,
  input  logic [WIB_REG_W-1:0] fetch_src0_i,
  input  logic                 fetch_src0_en_i,
  input  logic [WIB_REG_W-1:0] fetch_src1_i,
  input  logic                 fetch_src1_en_i,
  output logic                 issue_valid_o,
  input  logic                 issue_ready_i,
  output logic [WIB_OP_W-1:0]  issue_op_o,
  output logic [WIB_REG_W-1:0] issue_dst_o,
  output logic [WIB_REG_W-1:0] issue_src0_o,
  output logic                 issue_src0_en_o,
  output logic [WIB_REG_W-1:0] issue_src1_o,
  output logic                 issue_src1_en_o,
  input  logic                 wb_valid_i,
  input  logic [WIB_REG_W-1:0] wb_reg_i
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  wib_instr_t buf_q [DEPTH];
  wib_instr_t buf_n [DEPTH];
  wib_instr_t new_instr, sel_instr;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_after;

  logic [SB_SLOTS-1:0]                pend_valid;
  logic [SB_SLOTS-1:0][WIB_REG_W-1:0] pend_reg;
  logic                               sb_has_free;

  logic [DEPTH-1:0] hit, elig;
  logic [IDX_W-1:0] sel;
  logic             any_elig, issue_fire, fetch_fire;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    wib_hazard #(.SLOTS(SB_SLOTS)) u_hz (
      .instr_i     (buf_q[g]),
      .pend_valid_i(pend_valid),
      .pend_reg_i  (pend_reg),
      .hit_o       (hit[g])
    );
    assign elig[g] = (CNT_W'(g) < cnt_q) && !hit[g];
  end

  // lowest index is oldest
  always_comb begin
    sel      = '0;
    any_elig = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        sel      = IDX_W'(i);
        any_elig = 1'b1;
      end
    end
  end

  assign sel_instr     = buf_q[sel];
  assign issue_valid_o = any_elig && sb_has_free;
  assign issue_fire    = issue_valid_o && issue_ready_i;
  assign fetch_ready_o = cnt_q != CNT_W'(DEPTH);
  assign fetch_fire    = fetch_valid_i && fetch_ready_o;

  assign issue_op_o      = sel_instr.op;
  assign issue_dst_o     = sel_instr.dst;
  assign issue_src0_o    = sel_instr.src0;
  assign issue_src0_en_o = sel_instr.src0_en;
  assign issue_src1_o    = sel_instr.src1;
  assign issue_src1_en_o = sel_instr.src1_en;

  assign new_instr = '{op: fetch_op_i, dst: fetch_dst_i,
                       src0: fetch_src0_i, src0_en: fetch_src0_en_i,
                       src1: fetch_src1_i, src1_en: fetch_src1_en_i};

  // collapse the issued slot, then append at the tail
  always_comb begin
    for (int i = 0; i < DEPTH; i++) buf_n[i] = buf_q[i];
    cnt_after = cnt_q - CNT_W'(issue_fire);
    if (issue_fire) begin
      for (int i = 0; i < DEPTH - 1; i++)
        if (IDX_W'(i) >= sel) buf_n[i] = buf_q[i+1];
    end
    if (fetch_fire) buf_n[cnt_after[IDX_W-1:0]] = new_instr;
    cnt_n = cnt_after + CNT_W'(fetch_fire);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= buf_n[i];
    end
  end

  wib_scoreboard #(.SLOTS(SB_SLOTS)) u_sb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_valid_i (wb_valid_i),
    .clr_reg_i   (wb_reg_i),
    .set_valid_i (issue_fire),
    .set_reg_i   (sel_instr.dst),
    .pend_valid_o(pend_valid),
    .pend_reg_o  (pend_reg),
    .has_free_o  (sb_has_free)
  );
endmodule

// File: rtl/wib_checker.sv
module wib_checker
  import wib_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned SLOTS = 4
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            fetch_valid_i,
  input logic                            fetch_ready_o,
  input logic                            issue_valid_o,
  input logic                            issue_ready_i,
  input logic [WIB_REG_W-1:0]            issue_dst_o,
  input logic [WIB_REG_W-1:0]            issue_src0_o,
  input logic                            issue_src0_en_o,
  input logic [WIB_REG_W-1:0]            issue_src1_o,
  input logic                            issue_src1_en_o,
  input logic                            wb_valid_i,
  input logic [WIB_REG_W-1:0]            wb_reg_i,
  input logic [SLOTS-1:0]                pend_valid_i,
  input logic [SLOTS-1:0][WIB_REG_W-1:0] pend_reg_i
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]     occ_q;
  logic [WIB_REG_W-1:0] wb_reg_q, dst_q;
  logic issue_conf, wb_old_hit, dst_old_hit, wb_now_hit, dup;
  logic fetch_fire, issue_fire;

  assign fetch_fire = fetch_valid_i && fetch_ready_o;
  assign issue_fire = issue_valid_o && issue_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q    <= '0;
      wb_reg_q <= '0;
      dst_q    <= '0;
    end else begin
      occ_q    <= occ_q + CNT_W'(fetch_fire) - CNT_W'(issue_fire);
      wb_reg_q <= wb_reg_i;
      dst_q    <= issue_dst_o;
    end
  end

  always_comb begin
    issue_conf  = 1'b0;
    wb_old_hit  = 1'b0;
    dst_old_hit = 1'b0;
    wb_now_hit  = 1'b0;
    dup         = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (pend_valid_i[i]) begin
        if (pend_reg_i[i] == issue_dst_o ||
            (issue_src0_en_o && pend_reg_i[i] == issue_src0_o) ||
            (issue_src1_en_o && pend_reg_i[i] == issue_src1_o)) issue_conf = 1'b1;
        if (pend_reg_i[i] == wb_reg_q) wb_old_hit  = 1'b1;
        if (pend_reg_i[i] == dst_q)    dst_old_hit = 1'b1;
        if (pend_reg_i[i] == wb_reg_i) wb_now_hit  = 1'b1;
        for (int j = i + 1; j < SLOTS; j++)
          if (pend_valid_i[j] && pend_reg_i[j] == pend_reg_i[i]) dup = 1'b1;
      end
    end
  end

  AST_READY_MATCHES_OCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ready_o == (occ_q != CNT_W'(DEPTH))); // R4
  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= CNT_W'(DEPTH)); // R4
  AST_ISSUE_NO_HAZARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> !issue_conf); // R2
  AST_NO_DUP_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup); // R2
  AST_WB_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> !wb_old_hit); // R3
  AST_DST_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_fire |=> dst_old_hit); // R5
  AST_SLOT_AVAILABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> (!(&pend_valid_i) || (wb_valid_i && wb_now_hit))); // R7
endmodule

bind warp_issue_buf wib_checker #(.DEPTH(DEPTH), .SLOTS(SB_SLOTS)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fetch_valid_i  (fetch_valid_i),
  .fetch_ready_o  (fetch_ready_o),
  .issue_valid_o  (issue_valid_o),
  .issue_ready_i  (issue_ready_i),
  .issue_dst_o    (issue_dst_o),
  .issue_src0_o   (issue_src0_o),
  .issue_src0_en_o(issue_src0_en_o),
  .issue_src1_o   (issue_src1_o),
  .issue_src1_en_o(issue_src1_en_o),
  .wb_valid_i     (wb_valid_i),
  .wb_reg_i       (wb_reg_i),
  .pend_valid_i   (pend_valid),
  .pend_reg_i     (pend_reg)
);

// File: tb/sim_warp_issue_buf.sv
module sim_warp_issue_buf;
  import wib_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fetch_valid_i = 1'b0, fetch_ready_o;
  logic [WIB_OP_W-1:0]  fetch_op_i = '0;
  logic [WIB_REG_W-1:0] fetch_dst_i = '0, fetch_src0_i = '0, fetch_src1_i = '0;
  logic fetch_src0_en_i = 1'b0, fetch_src1_en_i = 1'b0;
  logic issue_valid_o, issue_ready_i = 1'b1;
  logic [WIB_OP_W-1:0]  issue_op_o;
  logic [WIB_REG_W-1:0] issue_dst_o, issue_src0_o, issue_src1_o;
  logic issue_src0_en_o, issue_src1_en_o;
  logic wb_valid_i = 1'b0;
  logic [WIB_REG_W-1:0] wb_reg_i = '0;

  int checks = 0;
  int errors = 0;
  logic [WIB_OP_W-1:0] exp_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  warp_issue_buf u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .fetch_valid_i(fetch_valid_i), .fetch_ready_o(fetch_ready_o),
    .fetch_op_i(fetch_op_i), .fetch_dst_i(fetch_dst_i),
    .fetch_src0_i(fetch_src0_i), .fetch_src0_en_i(fetch_src0_en_i),
    .fetch_src1_i(fetch_src1_i), .fetch_src1_en_i(fetch_src1_en_i),
    .issue_valid_o(issue_valid_o), .issue_ready_i(issue_ready_i),
    .issue_op_o(issue_op_o), .issue_dst_o(issue_dst_o),
    .issue_src0_o(issue_src0_o), .issue_src0_en_o(issue_src0_en_o),
    .issue_src1_o(issue_src1_o), .issue_src1_en_o(issue_src1_en_o),
    .wb_valid_i(wb_valid_i), .wb_reg_i(wb_reg_i)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every issue handshake is compared with the next expected tag
  always @(negedge clk) begin
    if (rst_ni && issue_valid_o && issue_ready_i) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected issue actual=%0d expected=none", issue_op_o);
      end else begin
        logic [WIB_OP_W-1:0] e;
        e = exp_q.pop_front();
        if (issue_op_o !== e) begin
          errors++;
          $display("FAIL R6 issue order actual=%0d expected=%0d", issue_op_o, e);
        end
      end
    end
  end

  task automatic drive(logic [7:0] op, logic [4:0] dst, logic [4:0] s0, logic e0,
                       logic [4:0] s1, logic e1);
    fetch_op_i = op; fetch_dst_i = dst;
    fetch_src0_i = s0; fetch_src0_en_i = e0;
    fetch_src1_i = s1; fetch_src1_en_i = e1;
    fetch_valid_i = 1'b1;
  endtask

  // driver: offer one instruction, wait for acceptance, record the expected issue
  task automatic fetch(logic [7:0] op, logic [4:0] dst, logic [4:0] s0, logic e0,
                       logic [4:0] s1, logic e1, bit expect_issue);
    drive(op, dst, s0, e0, s1, e1);
    if (expect_issue) exp_q.push_back(op);
    do @(negedge clk); while (!fetch_ready_o);
    @(posedge clk); #1;
    fetch_valid_i = 1'b0;
  endtask

  task automatic wb(logic [4:0] r);
    wb_reg_i = r; wb_valid_i = 1'b1;
    @(posedge clk); #1;
    wb_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 ready after reset", fetch_ready_o, 1);
    chk("R8 no issue after reset", issue_valid_o, 0);
    @(posedge clk); #1;

    // R1: independent stream issues in fetch order, fields intact
    drive(8'd1, 5'd1, 5'd30, 1'b1, 5'd31, 1'b1);
    @(negedge clk);
    chk("R1 not offered in accept cycle", issue_valid_o, 0);
    @(posedge clk); #1;
    fetch_valid_i = 1'b0;
    @(negedge clk);
    chk("R1 offered next cycle", issue_valid_o, 1);
    chk("R1 dst field", issue_dst_o, 1);
    chk("R1 src0 field", issue_src0_o, 30);
    chk("R1 src1 field", {issue_src1_en_o, issue_src1_o}, {1'b1, 5'd31});
    exp_q.push_back(8'd1);
    @(posedge clk); #1;
    fetch(8'd2, 5'd2, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    fetch(8'd3, 5'd3, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    idle(3);
    wb(5'd1); wb(5'd2); wb(5'd3);

    // R2/R3: RAW on src0
    fetch(8'd10, 5'd5, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    fetch(8'd11, 5'd6, 5'd5, 1'b1, 5'd0, 1'b0, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R2 src hazard blocks", issue_valid_o, 0);
    end
    @(posedge clk); #1;
    wb(5'd5);
    @(negedge clk);
    chk("R3 released after clear", issue_valid_o, 1);
    chk("R3 released dst", issue_dst_o, 6);
    @(posedge clk); #1;
    wb(5'd6);

    // R2: WAW on dst
    fetch(8'd20, 5'd7, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    fetch(8'd21, 5'd7, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    repeat (3) begin
      @(negedge clk);
      chk("R2 dst hazard blocks", issue_valid_o, 0);
    end
    @(posedge clk); #1;
    wb(5'd7);
    idle(2);
    wb(5'd7);

    // R2: disabled sources ignored
    fetch(8'd30, 5'd9, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    fetch(8'd31, 5'd20, 5'd9, 1'b0, 5'd9, 1'b0, 1);
    @(negedge clk);
    chk("R2 disabled sources not compared", issue_valid_o, 1);
    @(posedge clk); #1;
    wb(5'd9); wb(5'd20);

    // R6: younger independent passes older blocked
    fetch(8'd40, 5'd10, 5'd0, 1'b0, 5'd0, 1'b0, 0);
    exp_q.push_back(8'd40);
    fetch(8'd41, 5'd11, 5'd0, 1'b0, 5'd10, 1'b1, 0);
    fetch(8'd42, 5'd12, 5'd0, 1'b0, 5'd0, 1'b0, 0);
    exp_q.push_back(8'd42);
    exp_q.push_back(8'd41);
    idle(3);
    chk("R6 blocked older still waiting", exp_q.size(), 1);
    wb(5'd10);
    idle(2);
    wb(5'd11); wb(5'd12);

    // R4/R9: fill buffer with downstream stalled
    issue_ready_i = 1'b0;
    fetch(8'd50, 5'd13, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    fetch(8'd51, 5'd14, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    fetch(8'd52, 5'd15, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    fetch(8'd53, 5'd16, 5'd0, 1'b0, 5'd0, 1'b0, 1);
    drive(8'd54, 5'd17, 5'd0, 1'b0, 5'd0, 1'b0);
    exp_q.push_back(8'd54);
    repeat (2) begin
      @(negedge clk);
      chk("R4 backpressure when full", fetch_ready_o, 0);
      chk("R9 offer held while stalled", issue_valid_o, 1);
      chk("R9 oldest held", issue_op_o, 50);
    end
    @(posedge clk); #1;
    issue_ready_i = 1'b1;
    do @(negedge clk); while (!fetch_ready_o);
    @(posedge clk); #1;
    fetch_valid_i = 1'b0;
    idle(6);
    // R5: four slots full, instruction 54 must wait
    repeat (3) begin
      @(negedge clk);
      chk("R5 no slot blocks issue", issue_valid_o, 0);
    end
    chk("R5 drained four", exp_q.size(), 1);
    @(posedge clk); #1;
    // R7: clear and issue in the same cycle
    wb_reg_i = 5'd13; wb_valid_i = 1'b1;
    @(negedge clk);
    chk("R7 freed slot reused same cycle", issue_valid_o, 1);
    chk("R7 issued dst", issue_dst_o, 17);
    @(posedge clk); #1;
    wb_valid_i = 1'b0;
    // R5: dst 17 now pending, blocks a reader of 17
    fetch(8'd60, 5'd22, 5'd17, 1'b1, 5'd0, 1'b0, 1);
    @(negedge clk);
    chk("R5 issued dst recorded", issue_valid_o, 0);
    @(posedge clk); #1;
    wb(5'd17);
    idle(3);
    wb(5'd14); wb(5'd15); wb(5'd16); wb(5'd22);
    idle(2);
    chk("R6 all expected issues seen", exp_q.size(), 0);
    summary();
  end
endmodule